// File: doc/BRIEF.md
# Serial Byte and Block Synchronizer

The block receives a demodulated bit stream that arrives two bits per clock, earliest bit in the upper position, and is qualified by a valid strobe. The stream has no byte framing. The block rebuilds bytes from it, finds the bit offset at which bytes begin, and then locks onto a fixed block structure. Every block is 204 bytes long and opens with a sync byte whose value is either 0x47 or 0xB8.

While it hunts, the block compares the last eight received bits with both sync values at every bit position. The first match fixes both the byte alignment and the block phase. A lock level then counts consecutive sync bytes found exactly one block apart. The not-locked status clears only when that level reaches six. Once fully locked, a single missed sync costs one level rather than the whole lock. Aligned bytes leave the block with a one-cycle strobe and a start-of-block flag, ready for a de-interleaver downstream.

Top module: `sbb_sync`

## Requirements
- R1: Each cycle with `sym_valid_i` high carries two bits, `sym_bits_i[1]` received before `sym_bits_i[0]`; bytes are formed most significant bit first. An aligned byte appears on `byte_o` with `byte_vld_o` high in the cycle right after the clock edge that sampled its last bit. `byte_vld_o` is never high on two consecutive cycles.
- R2: Cycles with `sym_valid_i` low are ignored whatever `sym_bits_i` carries. Inserting them anywhere changes neither the byte sequence nor the flags.
- R3: At lock level 0 the last eight received bits are compared with the sync values after every single bit, so all eight bit offsets are searched. The first match fixes the alignment and makes that byte block position 0. That sync byte is not output; every later aligned byte is output.
- R4: Both 0x47 and 0xB8 are accepted as a sync byte at every lock level, in any order.
- R5: Each sync byte found at block position 0, that is 204 bytes after the previous one, raises the level by one up to 6. `no_lock_o` stays high until the sixth consecutive sync byte and goes low together with the output of that byte.
- R6: A non-sync byte at block position 0 at levels 1 to 5 returns the level to 0. That byte is still output with `no_lock_o` high, and no byte is output after it until the hunt finds a new sync byte.
- R7: A non-sync byte at block position 0 at level 6 lowers the level to 5 and raises `no_lock_o` from that byte on. The next sync byte restores level 6, while a second consecutive miss drops the level to 0.
- R8: `blk_start_o` is high only with a position-0 byte that is a sync byte and leaves the level at 6; it is low for every other byte.
- R9: While `rst` is high the block returns to level 0 on each clock edge: `no_lock_o` high, `byte_vld_o` and `blk_start_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sym_valid_i | input | 1 | Input bits valid this cycle |
| sym_bits_i | input | 2 | Two stream bits, bit 1 earlier |
| byte_o | output | 8 | Aligned output byte |
| byte_vld_o | output | 1 | `byte_o` holds a new byte |
| blk_start_o | output | 1 | Byte is the sync byte of a locked block |
| no_lock_o | output | 1 | High while not fully synchronized |

## Verification
The assertions check on every cycle that a gap cycle leaves the status unchanged and outputs no byte. They also check that bytes never come out back to back, that the block-start flag only appears with a locked, valid byte, and that lock is gained or lost only on an output byte. Whether the alignment is right for each of the eight bit offsets, whether the lock level climbs, steps down and falls exactly as the rules say, and whether the hunt resumes after a drop can only be shown by the bench. It does so by feeding known block streams and comparing every output byte and flag.

// File: rtl/sbb_sync_pkg.sv
package sbb_sync_pkg;
    localparam int unsigned DEF_SYM_W    = 2;
    localparam int unsigned DEF_BYTE_W   = 8;
    localparam int unsigned DEF_BLK_LEN  = 204;
    localparam int unsigned DEF_LOCK_MAX = 6;
    localparam int unsigned DEF_SYNC_A   = 32'h47;
    localparam int unsigned DEF_SYNC_B   = 32'hB8;
endpackage

// File: rtl/sbb_sync_cmp.sv
module sbb_sync_cmp #(
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned SYNC_A = 32'h47,
    parameter int unsigned SYNC_B = 32'hB8
) (
    input  logic [BYTE_W-1:0] win_i,
    output logic              hit_o
);
    assign hit_o = (win_i == BYTE_W'(SYNC_A)) || (win_i == BYTE_W'(SYNC_B));
endmodule

// File: rtl/sbb_bit_step.sv
module sbb_bit_step #(
    parameter int unsigned BYTE_W   = 8,
    parameter int unsigned BLK_LEN  = 204,
    parameter int unsigned LOCK_MAX = 6,
    parameter int unsigned SYNC_A   = 32'h47,
    parameter int unsigned SYNC_B   = 32'hB8,
    parameter int unsigned CNT_W    = $clog2(BYTE_W),
    parameter int unsigned POS_W    = $clog2(BLK_LEN),
    parameter int unsigned LVL_W    = $clog2(LOCK_MAX + 1)
) (
    input  logic              en_i,
    input  logic              bit_i,
    input  logic [BYTE_W-1:0] hist_i,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [POS_W-1:0]  pos_i,
    input  logic [LVL_W-1:0]  lvl_i,
    output logic [BYTE_W-1:0] hist_o,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [POS_W-1:0]  pos_o,
    output logic [LVL_W-1:0]  lvl_o,
    output logic              emit_o,
    output logic              sob_o
);
    localparam logic [LVL_W-1:0] LVL_TOP  = LVL_W'(LOCK_MAX);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);
    localparam logic [POS_W-1:0] POS_LAST = POS_W'(BLK_LEN - 1);

    logic [BYTE_W-1:0] hist_n;
    logic              hit;
    logic              last;

    assign hist_n = {hist_i[BYTE_W-2:0], bit_i};

    sbb_sync_cmp #(
        .BYTE_W (BYTE_W),
        .SYNC_A (SYNC_A),
        .SYNC_B (SYNC_B)
    ) cmp_i (
        .win_i (hist_n),
        .hit_o (hit)
    );

    always_comb begin
        hist_o = hist_i;
        cnt_o  = cnt_i;
        pos_o  = pos_i;
        lvl_o  = lvl_i;
        emit_o = 1'b0;
        sob_o  = 1'b0;
        last   = (cnt_i == CNT_LAST);
        if (en_i) begin
            hist_o = hist_n;
            if (lvl_i == '0) begin
                // hunting: every bit position is a candidate byte end
                if (hit) begin
                    lvl_o = LVL_W'(1);
                    cnt_o = '0;
                    pos_o = POS_W'(1);
                end
            end else begin
                cnt_o = last ? '0 : cnt_i + 1'b1;
                if (last) begin
                    emit_o = 1'b1;
                    pos_o  = (pos_i == POS_LAST) ? '0 : pos_i + 1'b1;
                    if (pos_i == '0) begin
                        if (hit) begin
                            lvl_o = (lvl_i == LVL_TOP) ? lvl_i : lvl_i + 1'b1;
                            sob_o = (lvl_i >= LVL_TOP - 1'b1);
                        end else begin
                            lvl_o = (lvl_i == LVL_TOP) ? lvl_i - 1'b1 : '0;
                        end
                    end
                end
            end
        end
    end
endmodule

// File: rtl/sbb_sync.sv
module sbb_sync #(
    parameter int unsigned SYM_W    = sbb_sync_pkg::DEF_SYM_W,
    parameter int unsigned BYTE_W   = sbb_sync_pkg::DEF_BYTE_W,
    parameter int unsigned BLK_LEN  = sbb_sync_pkg::DEF_BLK_LEN,
    parameter int unsigned LOCK_MAX = sbb_sync_pkg::DEF_LOCK_MAX,
    parameter int unsigned SYNC_A   = sbb_sync_pkg::DEF_SYNC_A,
    parameter int unsigned SYNC_B   = sbb_sync_pkg::DEF_SYNC_B
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sym_valid_i,
    input  logic [SYM_W-1:0]  sym_bits_i,
    output logic [BYTE_W-1:0] byte_o,
    output logic              byte_vld_o,
    output logic              blk_start_o,
    output logic              no_lock_o
);
    localparam int unsigned CNT_W = $clog2(BYTE_W);
    localparam int unsigned POS_W = $clog2(BLK_LEN);
    localparam int unsigned LVL_W = $clog2(LOCK_MAX + 1);

    typedef struct packed {
        logic [BYTE_W-1:0] hist;
        logic [CNT_W-1:0]  cnt;
        logic [POS_W-1:0]  pos;
        logic [LVL_W-1:0]  lvl;
        logic [BYTE_W-1:0] dat;
        logic              vld;
        logic              sob;
        logic              nosync;
    } st_t;

    st_t st_d, st_q;

    logic [SYM_W:0][BYTE_W-1:0] hist_c;
    logic [SYM_W:0][CNT_W-1:0]  cnt_c;
    logic [SYM_W:0][POS_W-1:0]  pos_c;
    logic [SYM_W:0][LVL_W-1:0]  lvl_c;
    logic [SYM_W-1:0]           emit_c;
    logic [SYM_W-1:0]           sob_c;

    assign hist_c[0] = st_q.hist;
    assign cnt_c[0]  = st_q.cnt;
    assign pos_c[0]  = st_q.pos;
    assign lvl_c[0]  = st_q.lvl;

    // one step per incoming bit, earliest bit (highest index) first
    for (genvar j = 0; j < SYM_W; j++) begin : g_step
        sbb_bit_step #(
            .BYTE_W   (BYTE_W),
            .BLK_LEN  (BLK_LEN),
            .LOCK_MAX (LOCK_MAX),
            .SYNC_A   (SYNC_A),
            .SYNC_B   (SYNC_B),
            .CNT_W    (CNT_W),
            .POS_W    (POS_W),
            .LVL_W    (LVL_W)
        ) step_i (
            .en_i   (sym_valid_i),
            .bit_i  (sym_bits_i[SYM_W-1-j]),
            .hist_i (hist_c[j]),
            .cnt_i  (cnt_c[j]),
            .pos_i  (pos_c[j]),
            .lvl_i  (lvl_c[j]),
            .hist_o (hist_c[j+1]),
            .cnt_o  (cnt_c[j+1]),
            .pos_o  (pos_c[j+1]),
            .lvl_o  (lvl_c[j+1]),
            .emit_o (emit_c[j]),
            .sob_o  (sob_c[j])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.hist = hist_c[SYM_W];
        st_d.cnt  = cnt_c[SYM_W];
        st_d.pos  = pos_c[SYM_W];
        st_d.lvl  = lvl_c[SYM_W];
        st_d.vld  = 1'b0;
        st_d.sob  = 1'b0;
        for (int j = 0; j < SYM_W; j++) begin
            if (emit_c[j]) begin
                st_d.dat = hist_c[j+1];
                st_d.vld = 1'b1;
                st_d.sob = sob_c[j];
            end
        end
        st_d.nosync = (lvl_c[SYM_W] != LVL_W'(LOCK_MAX));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= '0;
            st_q.nosync <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign byte_o      = st_q.dat;
    assign byte_vld_o  = st_q.vld;
    assign blk_start_o = st_q.sob;
    assign no_lock_o   = st_q.nosync;
endmodule

// File: rtl/sbb_sync_chk.sv
module sbb_sync_chk (
    input logic clk,
    input logic rst,
    input logic sym_valid_i,
    input logic byte_vld_o,
    input logic blk_start_o,
    input logic no_lock_o
);
    // R9: reset forces the hunting state on the outputs
    p_reset_state_r9: assert property (@(posedge clk)
        rst |=> (no_lock_o && !byte_vld_o && !blk_start_o));

    // R1: at most one byte per group of cycles, never back to back
    p_byte_spacing_r1: assert property (@(posedge clk) disable iff (rst)
        byte_vld_o |=> !byte_vld_o);

    // R2: a gap cycle produces no byte and leaves the status alone
    p_gap_ignored_r2: assert property (@(posedge clk) disable iff (rst)
        !sym_valid_i |=> (!byte_vld_o && $stable(no_lock_o)));

    // R8: block start only with a valid byte while locked
    p_start_locked_r8: assert property (@(posedge clk) disable iff (rst)
        blk_start_o |-> (byte_vld_o && !no_lock_o));

    // R5: lock is gained only together with a sync byte output
    p_lock_on_sync_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(no_lock_o) |-> blk_start_o);

    // R7: lock is lost only together with an output byte
    p_unlock_on_byte_r7: assert property (@(posedge clk) disable iff (rst)
        ($rose(no_lock_o) && !$past(rst)) |-> byte_vld_o);
endmodule

bind sbb_sync sbb_sync_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .sym_valid_i (sym_valid_i),
    .byte_vld_o  (byte_vld_o),
    .blk_start_o (blk_start_o),
    .no_lock_o   (no_lock_o)
);

// File: tb/sbb_sync_tb_top.sv
module sbb_sync_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sym_valid = 1'b0;
    logic [1:0] sym_bits = 2'b00;
    logic [7:0] byte_o;
    logic       byte_vld_o, blk_start_o, no_lock_o;

    always #4 clk = ~clk;

    sbb_sync dut_i (
        .clk         (clk),
        .rst         (rst),
        .sym_valid_i (sym_valid),
        .sym_bits_i  (sym_bits),
        .byte_o      (byte_o),
        .byte_vld_o  (byte_vld_o),
        .blk_start_o (blk_start_o),
        .no_lock_o   (no_lock_o)
    );

    typedef struct {
        logic [7:0] dat;
        logic       sob;
        logic       nl;
        string      tag;
    } exp_t;

    exp_t expq[$];
    exp_t e;
    bit   bq[$];
    int   n_chk = 0;
    int   n_fail = 0;
    int   m_lvl = 0;
    bit   gaps = 1'b0;
    bit   done = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // monitor: pops one expected item per output byte
    always @(negedge clk) begin
        if (!rst && byte_vld_o) begin
            if (expq.size() == 0) begin
                chk(1'b0, "R6", "byte output while none expected", int'(byte_o), 0);
            end else begin
                e = expq.pop_front();
                chk(byte_o == e.dat, "R1", "byte value", int'(byte_o), int'(e.dat));
                chk(blk_start_o == e.sob, "R8", "block start flag",
                    int'(blk_start_o), int'(e.sob));
                chk(no_lock_o == e.nl, e.tag, "not-locked status",
                    int'(no_lock_o), int'(e.nl));
            end
        end
    end

    // R2: gap cycles carry garbage bits that must be ignored
    task automatic send_sym(input logic [1:0] s);
        if (gaps && ($urandom_range(0, 3) == 0)) begin
            @(negedge clk);
            sym_valid = 1'b0;
            sym_bits  = 2'b11;
        end
        @(negedge clk);
        sym_valid = 1'b1;
        sym_bits  = s;
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            sym_valid = 1'b0;
            sym_bits  = 2'b10;
        end
    endtask

    task automatic drain();
        while (bq.size() >= 2) begin
            send_sym({bq[0], bq[1]});
            void'(bq.pop_front());
            void'(bq.pop_front());
        end
    endtask

    task automatic push_bit(input bit b);
        bq.push_back(b);
        drain();
    endtask

    task automatic push_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) bq.push_back(b[i]);
        drain();
    endtask

    task automatic flush();
        if (bq.size() == 1) bq.push_back(1'b0);
        drain();
        idle(8);
        chk(expq.size() == 0, "R3", "bytes still expected", expq.size(), 0);
        expq.delete();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        sym_valid = 1'b0;
        bq.delete();
        m_lvl = 0;
        repeat (2) @(negedge clk);
        chk(no_lock_o == 1'b1, "R9", "not-locked in reset", int'(no_lock_o), 1);
        chk(byte_vld_o == 1'b0, "R9", "byte valid in reset", int'(byte_vld_o), 0);
        chk(blk_start_o == 1'b0, "R9", "block start in reset", int'(blk_start_o), 0);
        rst = 1'b0;
    endtask

    // one 204-byte block; expected items follow R3, R5..R8 at byte level
    task automatic send_block(input logic [7:0] sync_val, input bit good,
                              input bit zero_pay, input int blk, input string tag);
        logic [7:0] b;
        bit emit, sob;
        for (int p = 0; p < 204; p++) begin
            if (p == 0) b = good ? sync_val : 8'h00;
            else        b = zero_pay ? 8'h00 : 8'(p * 3 + blk * 5 + 1);
            emit = 1'b0;
            sob  = 1'b0;
            if (p == 0) begin
                if (m_lvl == 0) begin
                    if (good) m_lvl = 1;
                end else begin
                    emit = 1'b1;
                    if (good) m_lvl = (m_lvl == 6) ? 6 : m_lvl + 1;
                    else      m_lvl = (m_lvl == 6) ? 5 : 0;
                    sob = good && (m_lvl == 6);
                end
            end else begin
                emit = (m_lvl != 0);
            end
            if (emit) expq.push_back('{dat: b, sob: sob, nl: (m_lvl != 6), tag: tag});
            push_byte(b);
        end
    endtask

    initial begin
        repeat (2) @(negedge clk);
        do_reset();

        // R3, R4, R5, R8: every bit offset, both sync values, gaps on odd offsets
        for (int off = 0; off < 8; off++) begin
            do_reset();
            gaps = off[0];
            for (int k = 0; k < 8 + off; k++) push_bit(1'b0);
            for (int blk = 0; blk < 7; blk++)
                send_block((((blk + off) % 8) == 0) ? 8'hB8 : 8'h47, 1'b1, 1'b0,
                           blk, "R5");
            flush();
        end

        // R6, R7: misses before and after full lock, hunt resumes
        do_reset();
        gaps = 1'b1;
        for (int k = 0; k < 3; k++) push_bit(1'b0);
        send_block(8'h47, 1'b1, 1'b1, 0, "R5");
        send_block(8'hB8, 1'b1, 1'b1, 1, "R5");
        send_block(8'h47, 1'b1, 1'b1, 2, "R5");
        send_block(8'h47, 1'b0, 1'b1, 3, "R6");
        for (int blk = 4; blk < 10; blk++)
            send_block((blk == 8) ? 8'hB8 : 8'h47, 1'b1, 1'b1, blk, "R5");
        send_block(8'h47, 1'b0, 1'b1, 10, "R7");
        send_block(8'hB8, 1'b1, 1'b1, 11, "R7");
        send_block(8'h47, 1'b0, 1'b1, 12, "R7");
        send_block(8'h47, 1'b0, 1'b1, 13, "R6");
        send_block(8'h47, 1'b1, 1'b1, 14, "R6");
        send_block(8'h47, 1'b1, 1'b1, 15, "R6");
        flush();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule